// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is a single compare channel that sits beside a shared free-running timer. It keeps a compare value in a register and checks it against the incoming timer count on every clock. When the two first become equal, the channel sends out a one-cycle match pulse, sets a sticky event flag, and updates its output pin according to a two-bit action code. The pin can be toggled, driven low or driven high. With the fourth code the pin is taken away from the timer.

Software can fire the pin action at any time with a force strobe, without waiting for a match. The flag clears when a 1 is written to it. In fast-clear mode, writing the compare value also clears the flag. An interrupt request is raised while the flag is set and the channel's interrupt enable is on. All pins are plain control and status signals with no stream handshake.

Top module: `oc_channel`

## Requirements
- R1: Action code `act_code` selects what a match or force does to the pin: 2'b01 toggles it, 2'b10 drives it to 0, 2'b11 drives it to 1, and 2'b00 does nothing. The pin changes on the clock edge that ends the cycle in which the event is seen.
- R2: When the compare channel is enabled and `tmr_count` equals the stored compare value, `match_pulse` is high in that cycle and `flag` is 1 from the next cycle on.
- R3: If the equality lasts several consecutive cycles, `match_pulse` is high only in the first of them, so the flag is set and the pin action applied once.
- R4: A cycle with `flag_wr`=1 and `flag_wr_bit`=1 clears the flag at the next edge. With `flag_wr_bit`=0 the flag keeps its value.
- R5: With `fast_clr`=1, a compare write (`cmp_wr`=1) clears the flag at the next edge. With `fast_clr`=0 the write leaves the flag alone.
- R6: `irq` is high exactly while `flag` and `irq_en` are both 1.
- R7: `force_cmp`=1 applies the pin action at the next edge as a match would, but leaves the flag unchanged.
- R8: With `cmp_mode`=0 no match is reported, the flag is not set, a force has no effect, and `pin_out` follows `gp_data`.
- R9: After reset, `flag`, `irq`, `match_pulse` and the stored pin level are 0, and the stored compare value is 0.
- R10: If a flag set and a flag clear happen in the same cycle, the set wins.
- R11: With action 2'b00, `pin_out` follows `gp_data` and the stored pin level is kept. It reappears when an active code is selected again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_count | input | CNT_W | Shared timer count |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wr_data | input | CNT_W | New compare value |
| cmp_mode | input | 1 | 1 = channel works as compare |
| act_code | input | 2 | Pin action code |
| irq_en | input | 1 | Interrupt enable |
| flag_wr | input | 1 | Flag write strobe |
| flag_wr_bit | input | 1 | Written flag bit, 1 clears |
| fast_clr | input | 1 | Compare write also clears flag |
| force_cmp | input | 1 | Force the pin action now |
| gp_data | input | 1 | General-purpose pin value |
| match_pulse | output | 1 | First-cycle equality pulse |
| flag | output | 1 | Event flag |
| irq | output | 1 | Interrupt request |
| pin_out | output | 1 | Output pin |

## Verification
The bench holds the count at the compare value for several cycles. A design that fires on every equal cycle would set the pin repeatedly and break the single toggle. It also runs a match together with a clear, where letting the clear win would lose the event. It checks a force with the flag low, where a design that sets the flag on a force would show a spurious flag. With the pin disconnected, it toggles the pin while the action code is 00; a design that overwrote the stored level would show the wrong value once the pin is reconnected. Other cases are a compare write in and out of fast-clear mode, a count wrap onto compare value 0, and a disabled channel whose count passes the compare value.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } oc_act_e;
endpackage

// File: rtl/oc_match_unit.sv
module oc_match_unit #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tmr_count,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wr_data,
  input  logic             cmp_mode,
  output logic             match_pulse
);
  logic [CNT_W-1:0] cmp_q;
  logic             eq_now;
  logic             eq_prev;

  assign eq_now      = cmp_mode && (tmr_count == cmp_q);
  assign match_pulse = eq_now && !eq_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q   <= '0;
      eq_prev <= 1'b0;
    end else begin
      eq_prev <= eq_now;
      if (cmp_wr) cmp_q <= cmp_wr_data;
    end
  end

  // R3: a pulse is never followed directly by another one
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |=> !match_pulse);
endmodule

// File: rtl/oc_flag_unit.sv
module oc_flag_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic flag_wr,
  input  logic flag_wr_bit,
  input  logic cmp_wr,
  input  logic fast_clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  logic clr_evt;

  assign clr_evt = (flag_wr && flag_wr_bit) || (cmp_wr && fast_clr);
  assign irq     = flag && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr_evt) flag <= 1'b0;
  end

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);
  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && flag_wr_bit && !set_evt) |=> !flag);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_evt && !flag_wr && !cmp_wr) |=> $stable(flag));
endmodule

// File: rtl/oc_pin_unit.sv
module oc_pin_unit
  import oc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic [1:0] act_code,
  input  logic       cmp_mode,
  input  logic       gp_data,
  output logic       pin_out
);
  oc_act_e act;
  logic    pin_q;
  logic    pin_d;

  assign act = oc_act_e'(act_code);

  always_comb begin
    pin_d = pin_q;
    if (fire) begin
      unique case (act)
        ACT_TOGGLE: pin_d = !pin_q;
        ACT_LOW:    pin_d = 1'b0;
        ACT_HIGH:   pin_d = 1'b1;
        default:    pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  assign pin_out = (cmp_mode && act != ACT_NONE) ? pin_q : gp_data;

  // R11: stored level only moves on an event with an active code
  p_pin_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire || act == ACT_NONE) |=> $stable(pin_q));
  p_drive_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && act == ACT_HIGH) |=> pin_q);
endmodule

// File: rtl/oc_channel.sv
module oc_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tmr_count,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wr_data,
  input  logic             cmp_mode,
  input  logic [1:0]       act_code,
  input  logic             irq_en,
  input  logic             flag_wr,
  input  logic             flag_wr_bit,
  input  logic             fast_clr,
  input  logic             force_cmp,
  input  logic             gp_data,
  output logic             match_pulse,
  output logic             flag,
  output logic             irq,
  output logic             pin_out
);
  logic fire;

  oc_match_unit #(.CNT_W(CNT_W)) u_match (
    .clk(clk), .rst_n(rst_n), .tmr_count(tmr_count), .cmp_wr(cmp_wr),
    .cmp_wr_data(cmp_wr_data), .cmp_mode(cmp_mode), .match_pulse(match_pulse)
  );

  oc_flag_unit u_flag (
    .clk(clk), .rst_n(rst_n), .set_evt(match_pulse), .flag_wr(flag_wr),
    .flag_wr_bit(flag_wr_bit), .cmp_wr(cmp_wr), .fast_clr(fast_clr),
    .irq_en(irq_en), .flag(flag), .irq(irq)
  );

  assign fire = match_pulse || (force_cmp && cmp_mode);

  oc_pin_unit u_pin (
    .clk(clk), .rst_n(rst_n), .fire(fire), .act_code(act_code),
    .cmp_mode(cmp_mode), .gp_data(gp_data), .pin_out(pin_out)
  );

  p_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag && irq_en));
  p_off_no_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_mode |-> !match_pulse);
  p_force_no_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !match_pulse) |=> !flag);
endmodule

// File: tb/oc_channel_tb.sv
module oc_channel_tb;
  localparam int CNT_W = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] cnt = '0, wd = '0;
  logic cw = 0, mode = 0, ie = 0, fw = 0, fd = 0, fast = 0, frc = 0, gp = 0;
  logic [1:0] act = 2'b00;
  logic match_pulse, flag, irq, pin_out;
  int checks = 0, fails = 0;
  string tag = "R9";

  // model state
  logic [CNT_W-1:0] m_cmp = '0;
  logic m_flag = 0, m_pin = 0, m_prev = 0;

  always #10 clk = ~clk;

  oc_channel #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tmr_count(cnt), .cmp_wr(cw), .cmp_wr_data(wd),
    .cmp_mode(mode), .act_code(act), .irq_en(ie), .flag_wr(fw),
    .flag_wr_bit(fd), .fast_clr(fast), .force_cmp(frc), .gp_data(gp),
    .match_pulse(match_pulse), .flag(flag), .irq(irq), .pin_out(pin_out)
  );

  task automatic chk(input string what, input logic act_v, input logic exp_v);
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act_v, exp_v, $time);
    end
  endtask

  // one cycle: compare at mid-low phase, then advance model on the edge
  task automatic tick();
    logic eq, mp, ev;
    #1;
    eq = mode && (cnt == m_cmp);
    mp = eq && !m_prev;
    chk("match_pulse", match_pulse, mp);
    chk("flag", flag, m_flag);
    chk("irq", irq, m_flag && ie);
    chk("pin_out", pin_out, (mode && act != 2'b00) ? m_pin : gp);
    @(posedge clk);
    if (mp) m_flag = 1;
    else if ((fw && fd) || (cw && fast)) m_flag = 0;
    ev = mp || (frc && mode);
    if (ev) begin
      if (act == 2'b01) m_pin = !m_pin;
      else if (act == 2'b10) m_pin = 0;
      else if (act == 2'b11) m_pin = 1;
    end
    m_prev = eq;
    if (cw) m_cmp = wd;
    @(negedge clk);
    cw = 0; fw = 0; fd = 0; frc = 0;
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R9: reset state
    tag = "R9";
    repeat (2) @(negedge clk);
    #1;
    chk("flag", flag, 1'b0);
    chk("irq", irq, 1'b0);
    chk("match_pulse", match_pulse, 1'b0);
    @(negedge clk);
    rst_n = 1;
    mode = 1; act = 2'b11; cnt = 16'd5;
    tick();
    // R2 and R1: compare 10, counting up, drive high
    tag = "R2";
    cw = 1; wd = 16'd10; tick();
    for (int i = 6; i < 15; i++) begin cnt = CNT_W'(i); tick(); end
    // R6: interrupt follows enable
    tag = "R6";
    ie = 1; tick(); ie = 0; tick(); ie = 1; tick();
    // R4: write 0 keeps, write 1 clears
    tag = "R4";
    fw = 1; fd = 0; tick();
    fw = 1; fd = 1; tick(); tick();
    // R3: count held at compare value, toggle once
    tag = "R3";
    act = 2'b01; cw = 1; wd = 16'd20; tick();
    cnt = 16'd20;
    for (int i = 0; i < 5; i++) tick();
    cnt = 16'd21; tick();
    // R5: compare write without then with fast clear
    tag = "R5";
    cw = 1; wd = 16'd100; fast = 0; tick(); tick();
    cw = 1; wd = 16'd101; fast = 1; tick(); tick();
    fast = 0;
    // R10: match and clear in the same cycle
    tag = "R10";
    act = 2'b10; cnt = 16'd101; fw = 1; fd = 1; tick();
    cnt = 16'd102; tick();
    fw = 1; fd = 1; tick();
    // R7: force with flag low sets no flag
    tag = "R7";
    act = 2'b11; frc = 1; tick(); tick();
    act = 2'b01; frc = 1; tick(); tick();
    // R11: disconnected pin follows gp_data, stored level kept
    tag = "R11";
    act = 2'b00;
    for (int i = 0; i < 4; i++) begin gp = ~gp; frc = 1; tick(); end
    act = 2'b01; tick();
    // R1: wrap onto compare value 0 with drive low
    tag = "R1";
    act = 2'b10; cw = 1; wd = 16'd0; cnt = 16'hFFFE; tick();
    cnt = 16'hFFFF; tick();
    cnt = 16'h0000; tick();
    cnt = 16'h0001; tick();
    fw = 1; fd = 1; tick();
    // R8: disabled channel
    tag = "R8";
    mode = 0; act = 2'b11; cw = 1; wd = 16'd50; tick();
    for (int i = 48; i < 53; i++) begin cnt = CNT_W'(i); gp = i[0]; tick(); end
    frc = 1; tick();
    mode = 1; cnt = 16'd60; tick();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule